// File: doc/BRIEF.md
# Peripheral Configuration Byte Port

This block is the processor-facing side of a byte-wide configuration loader. An external host selects the port with a pair of opposite-polarity chip selects. It then writes configuration bytes with an active-low write strobe. Each byte goes into a one-entry holding buffer, and a downstream bit serializer drains that buffer through a valid/ready handshake.

The host can pace itself in two ways. It can watch a dedicated ready pin. It can also issue a status read, which turns the data bus around: the top data bit reports ready/busy and the low bits carry the inverse of the held byte. All host strobes are synchronized into a single internal clock. Edge detection on the synchronized write strobe makes each strobe pulse load exactly one byte. The bidirectional data pads are modelled as separate data-out and output-enable vectors.

Top module: `cfg_byte_port`

## Requirements
- R1: The port counts as selected only while `csel_n` is 0 and `csel_p` is 1. With any other select combination, write and read strobes have no effect.
- R2: A falling edge of the synchronized `wr_n` while the port is selected captures `bus_in` into the holding buffer. Holding `wr_n` low loads only one byte.
- R3: `rdy_pin` is 1 when the buffer is empty. It goes to 0 on the clock after a capture and stays 0 until the serializer has accepted the byte.
- R4: `ser_valid` is 1 exactly while the buffer holds a byte, with `ser_data` equal to that byte. A cycle with `ser_valid` and `ser_ready` both high empties the buffer, and `ser_data` does not change while a byte waits.
- R5: A write that arrives while the buffer is full leaves the buffer unchanged and sets `overrun`. `overrun` stays 1 until reset.
- R6: While the port is selected, `rd_n` is 0 and `wr_n` is 1, `bus_oe` is all ones. In that state, `bus_out[7]` is 1 for ready and 0 for busy, and `bus_out[6:0]` is the bitwise inverse of bits 6:0 of the byte last loaded.
- R7: When `wr_n` and `rd_n` are both 0 while the port is selected, the write is performed and `bus_oe` stays all zeros.
- R8: Outside a selected status read, `bus_oe` is all zeros.
- R9: Reset (`rst` high, synchronous) leaves `rdy_pin` at 1, `ser_valid` at 0, `overrun` at 0 and `bus_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| csel_n | input | 1 | Active-low chip select |
| csel_p | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| rd_n | input | 1 | Active-low status read strobe (asynchronous) |
| bus_in | input | DW | Data bus as seen from the pads |
| bus_out | output | DW | Data driven onto the pads during a status read |
| bus_oe | output | DW | Per-bit pad output enable |
| rdy_pin | output | 1 | 1 = ready for a byte, 0 = busy |
| ser_data | output | DW | Byte offered to the serializer |
| ser_valid | output | 1 | Buffer holds a byte |
| ser_ready | input | 1 | Serializer accepts the offered byte |
| overrun | output | 1 | Sticky flag: a write was dropped |

## Verification
The hardest state to reach from the ports is a write strobe that stays low across the moment the serializer drains the buffer. That state separates edge-triggered capture from level-triggered capture. The stimulus holds `wr_n` low, pulses `ser_ready` while the strobe is still low, and then checks that the buffer stays empty. A second hard case is a write landing on a full buffer. The bench reaches it by holding `ser_ready` low over two back-to-back writes, then checks `overrun` and the unchanged `ser_data`.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef struct packed {
    logic cs_n;
    logic cs_p;
    logic wr_n;
    logic rd_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, cs_p: 1'b0, wr_n: 1'b1, rd_n: 1'b1};

  function automatic logic is_sel(input ctl_t c);
    return !c.cs_n && c.cs_p;
  endfunction
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgp_hold.sv
module cfgp_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] dout,
  output logic          ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      ovr  <= 1'b0;
      dout <= '0;
    end else begin
      if (load) begin
        if (full) begin
          ovr <= 1'b1;
        end else begin
          dout <= din;
          full <= 1'b1;
        end
      end
      if (full && take) full <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgp_stat.sv
module cfgp_stat #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_act,
  input  logic          full,
  input  logic [DW-1:0] held,
  output logic [DW-1:0] out,
  output logic [DW-1:0] oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out <= '0;
      oe  <= '0;
    end else begin
      oe  <= {DW{rd_act}};
      out <= {~full, ~held[DW-2:0]};
    end
  end
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csel_n,
  input  logic          csel_p,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] bus_oe,
  output logic          rdy_pin,
  output logic [DW-1:0] ser_data,
  output logic          ser_valid,
  input  logic          ser_ready,
  output logic          overrun
);
  import cfgp_pkg::*;

  localparam int CW = $bits(ctl_t);

  ctl_t          ctl_raw, ctl_s;
  logic [DW-1:0] dat_s;
  logic          wr_prev;
  logic          sel, wr_evt, rd_act, full;

  assign ctl_raw = '{cs_n: csel_n, cs_p: csel_p, wr_n: wr_n, rd_n: rd_n};

  cfgp_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) ctl_sync_i (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  cfgp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) dat_sync_i (
    .clk(clk), .rst(rst), .d(bus_in), .q(dat_s)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b1;
    else     wr_prev <= ctl_s.wr_n;
  end

  assign sel    = is_sel(ctl_s);
  assign wr_evt = sel && wr_prev && !ctl_s.wr_n;
  assign rd_act = sel && !ctl_s.rd_n && ctl_s.wr_n;

  cfgp_hold #(.DW(DW)) hold_i (
    .clk(clk), .rst(rst), .load(wr_evt), .din(dat_s),
    .take(ser_ready), .full(full), .dout(ser_data), .ovr(overrun)
  );

  cfgp_stat #(.DW(DW)) stat_i (
    .clk(clk), .rst(rst), .rd_act(rd_act), .full(full),
    .held(ser_data), .out(bus_out), .oe(bus_oe)
  );

  assign ser_valid = full;
  assign rdy_pin   = !full;
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] bus_out,
  input logic [DW-1:0] bus_oe,
  input logic          rdy_pin,
  input logic [DW-1:0] ser_data,
  input logic          ser_valid,
  input logic          ser_ready
);
  // R4
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_data)));

  // R3
  ready_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_pin) |-> $past(ser_valid && ser_ready));

  // R4
  drain_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_valid) |-> $past(ser_ready));

  // R8
  oe_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_oe == '0) || (bus_oe == '1));

  // R6
  status_bit_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe[DW-1] |-> (bus_out[DW-1] == $past(rdy_pin)));
endmodule

module cfgp_ovr_chk (
  input logic clk,
  input logic rst,
  input logic overrun
);
  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind cfg_byte_port cfgp_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .bus_out(bus_out), .bus_oe(bus_oe),
  .rdy_pin(rdy_pin), .ser_data(ser_data), .ser_valid(ser_valid),
  .ser_ready(ser_ready)
);

bind cfg_byte_port cfgp_ovr_chk ovr_chk_i (
  .clk(clk), .rst(rst), .overrun(overrun)
);

// File: tb/cfg_byte_port_tb_top.sv
module cfg_byte_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csel_n = 1'b1, csel_p = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out, bus_oe, ser_data;
  logic       rdy_pin, ser_valid, overrun;
  logic       ser_ready = 1'b0;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  cfg_byte_port dut_i (
    .clk(clk), .rst(rst), .csel_n(csel_n), .csel_p(csel_p), .wr_n(wr_n),
    .rd_n(rd_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .rdy_pin(rdy_pin), .ser_data(ser_data), .ser_valid(ser_valid),
    .ser_ready(ser_ready), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic cn, input logic cp, input logic [7:0] d);
    @(negedge clk);
    csel_n = cn; csel_p = cp; bus_in = d; wr_n = 1'b0;
    cyc(6);
    wr_n = 1'b1;
    cyc(4);
    csel_n = 1'b1; csel_p = 1'b0;
    cyc(4);
  endtask

  task automatic accept();
    @(negedge clk); ser_ready = 1'b1;
    @(negedge clk); ser_ready = 1'b0;
  endtask

  task automatic status_read(input logic cn, input logic cp,
                             input int exp_oe, input int exp_out, input string tag);
    @(negedge clk);
    csel_n = cn; csel_p = cp; rd_n = 1'b0;
    cyc(5);
    chk({tag, " oe"}, bus_oe, exp_oe);
    if (exp_oe != 0) chk({tag, " data"}, bus_out, exp_out);
    rd_n = 1'b1; csel_n = 1'b1; csel_p = 1'b0;
    cyc(5);
    chk("R8 oe released", bus_oe, 0);
  endtask

  task automatic t_reset();
    chk("R9 rdy", rdy_pin, 1);
    chk("R9 valid", ser_valid, 0);
    chk("R9 overrun", overrun, 0);
    chk("R9 oe", bus_oe, 0);
  endtask

  task automatic t_unselected();
    do_write(1'b1, 1'b1, 8'h99);
    chk("R1 cs_n high ignored", ser_valid, 0);
    do_write(1'b0, 1'b0, 8'h99);
    chk("R1 cs_p low ignored", ser_valid, 0);
    status_read(1'b1, 1'b0, 0, 0, "R1 read unselected");
  endtask

  task automatic t_write_read();
    do_write(1'b0, 1'b1, 8'hA5);
    chk("R2 valid", ser_valid, 1);
    chk("R4 data", ser_data, 8'hA5);
    chk("R3 busy", rdy_pin, 0);
    cyc(20);
    chk("R3 still busy", rdy_pin, 0);
    status_read(1'b0, 1'b1, 8'hFF, 8'h5A, "R6 busy");
    accept();
    chk("R4 drained", ser_valid, 0);
    chk("R3 ready", rdy_pin, 1);
    status_read(1'b0, 1'b1, 8'hFF, 8'hDA, "R6 ready");
  endtask

  task automatic t_overrun();
    do_write(1'b0, 1'b1, 8'h3C);
    do_write(1'b0, 1'b1, 8'hC3);
    chk("R5 overrun", overrun, 1);
    chk("R5 data kept", ser_data, 8'h3C);
    accept();
    do_write(1'b0, 1'b1, 8'h11);
    chk("R5 sticky", overrun, 1);
    chk("R5 later write ok", ser_data, 8'h11);
    accept();
  endtask

  task automatic t_priority();
    @(negedge clk);
    csel_n = 1'b0; csel_p = 1'b1; bus_in = 8'h7E; wr_n = 1'b0; rd_n = 1'b0;
    cyc(6);
    chk("R7 no oe", bus_oe, 0);
    chk("R7 write done", ser_data, 8'h7E);
    wr_n = 1'b1; rd_n = 1'b1; csel_n = 1'b1; csel_p = 1'b0;
    cyc(4);
    accept();
  endtask

  task automatic t_one_pulse();
    @(negedge clk);
    csel_n = 1'b0; csel_p = 1'b1; bus_in = 8'h42; wr_n = 1'b0;
    cyc(6);
    chk("R2 captured", ser_data, 8'h42);
    accept();
    cyc(10);
    chk("R2 one byte per pulse", ser_valid, 0);
    wr_n = 1'b1; csel_n = 1'b1; csel_p = 1'b0;
    cyc(4);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    cyc(3); rst = 1'b0;
    cyc(2);
    chk("R9 overrun cleared", overrun, 0);
    chk("R9 rdy after reset", rdy_pin, 1);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_unselected();
    t_write_read();
    t_overrun();
    t_priority();
    t_one_pulse();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule